// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Sequencer

This block moves data inside a memory space on behalf of a CPU. It has two channels. Each channel holds a source pointer, a destination pointer, a unit counter and a control word. A shared control word holds a global run enable, a sticky NMI flag and a sticky address-error flag. When a channel is allowed to run and has a request, the block performs one transfer unit. A unit is a read from the source pointer followed, in the next cycle, by a write of that data to the destination pointer. Both pointers then advance and the counter steps down.

Software programs the channel registers, sets the channel and global enables, and either lets the channel run on its own (auto-request) or pulses the channel's request input once per unit. When the counter reaches zero, the channel raises its end flag and, if enabled, its end interrupt. An NMI event, an address-error event, or clearing an enable stops the work at once. A unit that has been read but not yet written is dropped without changing any channel state.

Register map, selected by `reg_addr`: channel c uses addresses 4c+0 (source), 4c+1 (destination), 4c+2 (count) and 4c+3 (control). The shared control word is at address 8. Control word bits: 0 = channel enable, 1 = interrupt enable, 2 = auto-request, 3 = end flag. Shared word bits: 0 = global enable, 1 = NMI flag, 2 = address-error flag. Unmapped addresses read 0 and ignore writes. Reads return data combinationally in the cycle `reg_re` is high.

Top module: `dual_dma_seq`

## Requirements
- R1: After reset all channel registers, the shared word, `irq`, `mem_rd` and `mem_wr` are 0.
- R2: A channel starts or continues a unit only while its enable (control bit 0) is 1, the global enable (shared bit 0) is 1, its end flag (control bit 3) is 0, and both the NMI flag (shared bit 1) and address-error flag (shared bit 2) are 0. A channel whose count is 0 never starts.
- R3: With auto-request (control bit 2) set, an allowed channel starts without any request. Without it, a unit starts only when `req_in[c]` is high in a cycle where no unit is in progress.
- R4: A unit takes a start cycle, a read cycle (`mem_rd`=1, `mem_addr`=source) and then a write cycle (`mem_wr`=1, `mem_addr`=destination, `mem_wdata`=the data read). After the write, source and destination each advance by UNIT (1 by default).
- R5: Each completed write decrements the channel count by exactly 1.
- R6: The write that takes the count from 1 to 0 sets the end flag, and the channel then stops.
- R7: `irq[c]` is 1 exactly while channel c's end flag and interrupt enable are both 1.
- R8: Writing 0 to the end flag clears it only if the control word was read with the flag at 1 since the flag was last cleared. Otherwise the flag stays 1. Writing 1 never sets it.
- R9: When both channels may start in the same cycle, channel 0 goes first. A new channel is picked only between units, so a unit is never interleaved with another.
- R10: If the active channel stops being allowed (enable cleared, NMI or address error) after its read, the write is suppressed and its pointers and count keep their values.
- R11: `nmi_evt` and `aerr_evt` set their flags. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (0 when not reading) |
| req_in | input | 2 | Per-channel transfer request |
| nmi_evt | input | 1 | NMI event pulse |
| aerr_evt | input | 1 | Address-error event pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address (0 when idle) |
| mem_wdata | output | 16 | Memory write data (0 when not writing) |
| mem_rdata | input | 16 | Memory read data, valid in the read cycle |
| irq | output | 2 | Per-channel end interrupt |

## Verification
A wrong pointer, count or picked channel shows on `mem_addr` within the next unit, at most three cycles later. A wrong latched word shows on `mem_wdata` in the very next cycle. Flag and arming errors show up in two ways: a stuck or missing `irq`, or a unit that runs or stalls when it should not. These appear in the first cycle after the faulty flag edge. A missed abort shows as a write strobe in the cycle after the event.

// File: rtl/dual_dma_pkg.sv
package dual_dma_pkg;
  // register field selectors within a channel's four-word window
  localparam logic [1:0] FLD_SRC = 2'd0;
  localparam logic [1:0] FLD_DST = 2'd1;
  localparam logic [1:0] FLD_CNT = 2'd2;
  localparam logic [1:0] FLD_CTL = 2'd3;

  // channel control word bits
  localparam int CTL_EN   = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_AUTO = 2;
  localparam int CTL_DONE = 3;

  // shared control word bits
  localparam int OPR_MASTER = 0;
  localparam int OPR_NMI    = 1;
  localparam int OPR_AERR   = 2;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xfer_state_e;

  // the five-way gate that lets a channel run
  function automatic logic may_run(input logic en, input logic master,
                                   input logic done, input logic nmi,
                                   input logic aerr);
    return en & master & ~done & ~nmi & ~aerr;
  endfunction
endpackage

// File: rtl/dual_dma_chan.sv
module dual_dma_chan
  import dual_dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DW   = 16,
  parameter int UNIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we_i,
  input  logic [1:0]    cpu_field_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_rd_ctl_i,
  input  logic          unit_done_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          en_o,
  output logic          ie_o,
  output logic          auto_o,
  output logic          done_o
);
  logic armed_q;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(UNIT);
  endfunction

  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  // named events for the checks below
  logic last_unit, cpu_cnt_wr, flag_clear_req;
  assign last_unit      = unit_done_i && (cnt_o == CW'(1));
  assign cpu_cnt_wr     = cpu_we_i && (cpu_field_i == FLD_CNT);
  assign flag_clear_req = cpu_we_i && (cpu_field_i == FLD_CTL) && !cpu_wdata_i[CTL_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o   <= '0;
      dst_o   <= '0;
      cnt_o   <= '0;
      en_o    <= 1'b0;
      ie_o    <= 1'b0;
      auto_o  <= 1'b0;
      done_o  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (unit_done_i) begin
        src_o <= step_addr(src_o);
        dst_o <= step_addr(dst_o);
        cnt_o <= step_count(cnt_o);
        if (last_unit) done_o <= 1'b1;
      end
      if (cpu_rd_ctl_i && done_o) armed_q <= 1'b1;
      if (cpu_we_i) begin
        case (cpu_field_i)
          FLD_SRC: src_o <= cpu_wdata_i[AW-1:0];
          FLD_DST: dst_o <= cpu_wdata_i[AW-1:0];
          FLD_CNT: cnt_o <= cpu_wdata_i[CW-1:0];
          default: begin
            en_o   <= cpu_wdata_i[CTL_EN];
            ie_o   <= cpu_wdata_i[CTL_IE];
            auto_o <= cpu_wdata_i[CTL_AUTO];
            if (flag_clear_req && armed_q) begin
              done_o  <= 1'b0;
              armed_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done_i && !cpu_cnt_wr) |=> (cnt_o == $past(cnt_o) - CW'(1)));

  a_r6_end_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    last_unit |=> done_o);

  a_r8_flag_holds_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !armed_q) |=> done_o);
endmodule

// File: rtl/dual_dma_opr.sv
module dual_dma_opr
  import dual_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_we_i,
  input  logic [2:0] cpu_bits_i,
  input  logic       nmi_evt_i,
  input  logic       aerr_evt_i,
  output logic       master_o,
  output logic       nmi_o,
  output logic       aerr_o
);
  logic nmi_clear, aerr_clear;
  assign nmi_clear  = cpu_we_i && !cpu_bits_i[OPR_NMI];
  assign aerr_clear = cpu_we_i && !cpu_bits_i[OPR_AERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_o <= 1'b0;
      nmi_o    <= 1'b0;
      aerr_o   <= 1'b0;
    end else begin
      if (cpu_we_i) master_o <= cpu_bits_i[OPR_MASTER];
      nmi_o  <= nmi_evt_i  | (nmi_o  & ~nmi_clear);
      aerr_o <= aerr_evt_i | (aerr_o & ~aerr_clear);
    end
  end

  a_r11_nmi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt_i |=> nmi_o);

  a_r11_aerr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    aerr_evt_i |=> aerr_o);
endmodule

// File: rtl/dual_dma_engine.sv
module dual_dma_engine
  import dual_dma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           ready_i,
  input  logic [NCH-1:0]           run_ok_i,
  input  logic [NCH-1:0][AW-1:0]   src_i,
  input  logic [NCH-1:0][AW-1:0]   dst_i,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic                     mem_rd_o,
  output logic                     mem_wr_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  output logic [NCH-1:0]           unit_done_o
);
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

  xfer_state_e    state_q;
  logic [CIW-1:0] act_q;
  logic [DW-1:0]  data_q;

  // lowest index wins
  function automatic logic [CIW-1:0] first_set(input logic [NCH-1:0] v);
    logic [CIW-1:0] idx;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) idx = CIW'(i);
    end
    return idx;
  endfunction

  logic act_ok, start_unit;
  assign act_ok     = run_ok_i[act_q];
  assign start_unit = (state_q == XF_IDLE) && (|ready_i);

  always_comb begin
    mem_rd_o    = (state_q == XF_READ)  && act_ok;
    mem_wr_o    = (state_q == XF_WRITE) && act_ok;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unit_done_o = '0;
    if (mem_rd_o) mem_addr_o = src_i[act_q];
    if (mem_wr_o) begin
      mem_addr_o         = dst_i[act_q];
      mem_wdata_o        = data_q;
      unit_done_o[act_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      act_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        XF_IDLE: begin
          if (start_unit) begin
            act_q   <= first_set(ready_i);
            state_q <= XF_READ;
          end
        end
        XF_READ: begin
          if (act_ok) begin
            data_q  <= mem_rdata_i;
            state_q <= XF_WRITE;
          end else begin
            state_q <= XF_IDLE;
          end
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> $past(mem_rd_o));

  a_r9_one_unit_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_done_o));

  a_r9_no_regrant_mid_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != XF_IDLE) |=> $stable(act_q));
endmodule

// File: rtl/dual_dma_seq.sv
module dual_dma_seq
  import dual_dma_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DW   = 16,
  parameter int UNIT = 1,
  parameter int RAW  = $clog2(4 * NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic           reg_re,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] req_in,
  input  logic           nmi_evt,
  input  logic           aerr_evt,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [NCH-1:0] irq
);
  localparam logic [RAW-1:0] OPR_ADDR = RAW'(4 * NCH);

  logic                   opr_hit;
  logic [1:0]             fld;
  logic                   master, nmi_q, aerr_q;
  logic [NCH-1:0][AW-1:0] src_all, dst_all;
  logic [NCH-1:0][CW-1:0] cnt_all;
  logic [NCH-1:0]         en, ie, auto_rq, done, run_ok, ready, unit_done;

  assign opr_hit = (reg_addr == OPR_ADDR);
  assign fld     = reg_addr[1:0];

  dual_dma_opr u_opr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_we_i   (reg_we && opr_hit),
    .cpu_bits_i (reg_wdata[2:0]),
    .nmi_evt_i  (nmi_evt),
    .aerr_evt_i (aerr_evt),
    .master_o   (master),
    .nmi_o      (nmi_q),
    .aerr_o     (aerr_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (reg_addr[RAW-1:2] == (RAW-2)'(c));

    dual_dma_chan #(.AW(AW), .CW(CW), .DW(DW), .UNIT(UNIT)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_we_i     (reg_we && hit),
      .cpu_field_i  (fld),
      .cpu_wdata_i  (reg_wdata),
      .cpu_rd_ctl_i (reg_re && hit && (fld == FLD_CTL)),
      .unit_done_i  (unit_done[c]),
      .src_o        (src_all[c]),
      .dst_o        (dst_all[c]),
      .cnt_o        (cnt_all[c]),
      .en_o         (en[c]),
      .ie_o         (ie[c]),
      .auto_o       (auto_rq[c]),
      .done_o       (done[c])
    );

    assign run_ok[c] = may_run(en[c], master, done[c], nmi_q, aerr_q);
    assign ready[c]  = run_ok[c] && (cnt_all[c] != '0) && (auto_rq[c] || req_in[c]);
    assign irq[c]    = done[c] & ie[c];
  end

  dual_dma_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready),
    .run_ok_i    (run_ok),
    .src_i       (src_all),
    .dst_i       (dst_all),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .unit_done_o (unit_done)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      if (opr_hit) reg_rdata = DW'({aerr_q, nmi_q, master});
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr[RAW-1:2] == (RAW-2)'(c)) begin
          case (fld)
            FLD_SRC: reg_rdata = DW'(src_all[c]);
            FLD_DST: reg_rdata = DW'(dst_all[c]);
            FLD_CNT: reg_rdata = DW'(cnt_all[c]);
            default: reg_rdata = DW'({done[c], auto_rq[c], ie[c], en[c]});
          endcase
        end
      end
    end
  end

  a_r2_idle_without_master: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !(mem_rd || mem_wr));

  a_r10_flags_block_access: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q || aerr_q) |-> !(mem_rd || mem_wr));

  a_r6_finished_channel_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (done == '1) |-> !(mem_rd || mem_wr));
endmodule

// File: tb/dual_dma_seq_bench.sv
`timescale 1ns/1ps
module dual_dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  req_in = '0;
  logic        nmi_evt = 1'b0, aerr_evt = 1'b0;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] memval(input logic [15:0] a);
    return (a * 16'h0013) ^ 16'h5A5A;
  endfunction

  assign mem_rdata = memval(mem_addr);

  dual_dma_seq u_dual_dma_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_in(req_in), .nmi_evt(nmi_evt), .aerr_evt(aerr_evt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_src [2];
  logic [15:0] m_dst [2];
  logic [15:0] m_cnt [2];
  bit          m_en [2], m_ie [2], m_auto [2], m_done [2], m_armed [2];
  bit          m_master, m_nmi, m_ae;
  int          m_st, m_act;
  logic [15:0] m_data;

  function automatic bit allowed(input int c);
    return m_en[c] && m_master && !m_done[c] && !m_nmi && !m_ae;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0;
        m_en[c] = 0; m_ie[c] = 0; m_auto[c] = 0; m_done[c] = 0; m_armed[c] = 0;
      end
      m_master = 0; m_nmi = 0; m_ae = 0; m_st = 0; m_act = 0; m_data = '0;
    end else begin
      bit ok0, ok1;
      ok0 = allowed(0);
      ok1 = allowed(1);
      if (m_st == 0) begin
        if (ok0 && m_cnt[0] != 16'd0 && (m_auto[0] || req_in[0])) begin
          m_act = 0; m_st = 1;
        end else if (ok1 && m_cnt[1] != 16'd0 && (m_auto[1] || req_in[1])) begin
          m_act = 1; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (m_act == 0 ? ok0 : ok1) begin
          m_data = memval(m_src[m_act]); m_st = 2;
        end else m_st = 0;
      end else begin
        if (m_act == 0 ? ok0 : ok1) begin
          m_src[m_act] = m_src[m_act] + 16'd1;
          m_dst[m_act] = m_dst[m_act] + 16'd1;
          m_cnt[m_act] = m_cnt[m_act] - 16'd1;
          if (m_cnt[m_act] == 16'd0) m_done[m_act] = 1;
        end
        m_st = 0;
      end
      if (reg_re && reg_addr < 4'd8 && reg_addr[1:0] == 2'd3 && m_done[reg_addr[2]])
        m_armed[reg_addr[2]] = 1;
      if (reg_we) begin
        if (reg_addr == 4'd8) begin
          m_master = reg_wdata[0];
          if (!reg_wdata[1]) m_nmi = 0;
          if (!reg_wdata[2]) m_ae = 0;
        end else if (reg_addr < 4'd8) begin
          int c;
          c = int'(reg_addr[2]);
          case (reg_addr[1:0])
            2'd0: m_src[c] = reg_wdata;
            2'd1: m_dst[c] = reg_wdata;
            2'd2: m_cnt[c] = reg_wdata;
            default: begin
              m_en[c] = reg_wdata[0]; m_ie[c] = reg_wdata[1]; m_auto[c] = reg_wdata[2];
              if (!reg_wdata[3] && m_armed[c]) begin m_done[c] = 0; m_armed[c] = 0; end
            end
          endcase
        end
      end
      if (nmi_evt) m_nmi = 1;
      if (aerr_evt) m_ae = 1;
    end
  end

  function automatic logic [15:0] exp_rdata();
    int c;
    if (!reg_re) return 16'h0;
    if (reg_addr == 4'd8) return {13'b0, m_ae, m_nmi, m_master};
    if (reg_addr > 4'd8) return 16'h0;
    c = int'(reg_addr[2]);
    case (reg_addr[1:0])
      2'd0: return m_src[c];
      2'd1: return m_dst[c];
      2'd2: return m_cnt[c];
      default: return {12'b0, m_done[c], m_auto[c], m_ie[c], m_en[c]};
    endcase
  endfunction

  // per-cycle comparison and logging, away from the active edge
  logic [15:0] rd_log [16];
  int          rd_n = 0;
  logic [15:0] last_wr_addr = '0, last_wr_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rd, e_wr, aok;
      logic [15:0] e_addr, e_wdata;
      aok     = allowed(m_act);
      e_rd    = (m_st == 1) && aok;
      e_wr    = (m_st == 2) && aok;
      e_addr  = e_rd ? m_src[m_act] : (e_wr ? m_dst[m_act] : 16'h0);
      e_wdata = e_wr ? m_data : 16'h0;
      chk("R4", "mem_rd", 16'(mem_rd), 16'(e_rd));
      chk("R4", "mem_wr", 16'(mem_wr), 16'(e_wr));
      chk("R4", "mem_addr", mem_addr, e_addr);
      chk("R4", "mem_wdata", mem_wdata, e_wdata);
      chk("R7", "irq", 16'(irq), {14'b0, m_done[1] & m_ie[1], m_done[0] & m_ie[0]});
      chk("R8", "reg_rdata", reg_rdata, exp_rdata());
      if (mem_rd && rd_n < 16) begin rd_log[rd_n] = mem_addr; rd_n++; end
      if (mem_wr) begin last_wr_addr = mem_addr; last_wr_data = mem_wdata; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    wait_cycles(3);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1", "mem_rd after reset", 16'(mem_rd), 16'h0);
    chk("R1", "irq after reset", 16'(irq), 16'h0);
    rd(4'd8, v); chk("R1", "shared word", v, 16'h0000);
    rd(4'd3, v); chk("R1", "ch0 control", v, 16'h0000);
    rd(4'd6, v); chk("R1", "ch1 count", v, 16'h0000);

    // R11 flag set, write-1 keeps, write-0 clears
    @(posedge clk); #1 nmi_evt = 1'b1;
    @(posedge clk); #1 nmi_evt = 1'b0;
    rd(4'd8, v); chk("R11", "nmi set by event", v, 16'h0002);
    wr(4'd8, 16'h0003);
    rd(4'd8, v); chk("R11", "nmi kept by write 1", v, 16'h0003);
    wr(4'd8, 16'h0001);
    rd(4'd8, v); chk("R11", "nmi cleared by write 0", v, 16'h0001);
    @(posedge clk); #1 aerr_evt = 1'b1;
    @(posedge clk); #1 aerr_evt = 1'b0;
    rd(4'd8, v); chk("R11", "aerr set by event", v, 16'h0005);
    wr(4'd8, 16'h0001);
    rd(4'd8, v); chk("R11", "aerr cleared", v, 16'h0001);

    // R4 R5 R6 R7: auto-request block of three units on channel 0
    wr(4'd0, 16'h0100); wr(4'd1, 16'h0200); wr(4'd2, 16'd3);
    wr(4'd3, 16'h0007);
    wait_cycles(15);
    @(negedge clk);
    chk("R7", "irq0 at end", 16'(irq), 16'h0001);
    chk("R4", "last write address", last_wr_addr, 16'h0202);
    chk("R4", "last write data", last_wr_data, memval(16'h0102));
    rd(4'd2, v); chk("R5", "count reached zero", v, 16'h0000);
    rd(4'd0, v); chk("R4", "source advanced", v, 16'h0103);
    rd(4'd1, v); chk("R4", "destination advanced", v, 16'h0203);

    // R8: clear without prior read is ignored, then read-then-clear works
    wr(4'd3, 16'h0007);
    @(negedge clk); chk("R8", "irq kept without read", 16'(irq), 16'h0001);
    rd(4'd3, v); chk("R6", "end flag set", v, 16'h000F);
    wr(4'd3, 16'h0007);
    rd(4'd3, v); chk("R8", "end flag cleared after read", v, 16'h0007);
    @(negedge clk); chk("R7", "irq dropped", 16'(irq), 16'h0000);

    // R3: channel 1 without auto-request waits for req_in
    wr(4'd4, 16'h0300); wr(4'd5, 16'h0400); wr(4'd6, 16'd2);
    wr(4'd7, 16'h0001);
    wait_cycles(10);
    rd(4'd6, v); chk("R3", "no request no transfer", v, 16'd2);
    @(posedge clk); #1 req_in = 2'b10;
    @(posedge clk); #1 req_in = 2'b00;
    wait_cycles(6);
    rd(4'd6, v); chk("R3", "one request one unit", v, 16'd1);
    rd(4'd4, v); chk("R3", "source after one unit", v, 16'h0301);

    // R2 with global enable off, then R9 priority
    wr(4'd8, 16'h0000);
    wr(4'd0, 16'h0500); wr(4'd1, 16'h0600); wr(4'd2, 16'd2); wr(4'd3, 16'h0005);
    wr(4'd4, 16'h0700); wr(4'd5, 16'h0800); wr(4'd6, 16'd2); wr(4'd7, 16'h0005);
    rd_n = 0;
    wait_cycles(8);
    rd(4'd2, v); chk("R2", "count held with global enable off", v, 16'd2);
    chk("R2", "no reads with global enable off", 16'(rd_n), 16'h0);
    wr(4'd8, 16'h0001);
    wait_cycles(20);
    chk("R9", "read count", 16'(rd_n), 16'd4);
    chk("R9", "first unit from ch0", rd_log[0], 16'h0500);
    chk("R9", "second unit from ch0", rd_log[1], 16'h0501);
    chk("R9", "third unit from ch1", rd_log[2], 16'h0700);
    chk("R9", "fourth unit from ch1", rd_log[3], 16'h0701);

    // R10: NMI between read and write drops the unit
    rd(4'd3, v); wr(4'd3, 16'h0000);
    wr(4'd0, 16'h0900); wr(4'd1, 16'h0A00); wr(4'd2, 16'd5);
    wr(4'd3, 16'h0005);
    forever begin
      @(negedge clk);
      if (mem_rd && mem_addr == 16'h0902) break;
    end
    #1 nmi_evt = 1'b1;
    @(posedge clk); #1 nmi_evt = 1'b0;
    wait_cycles(8);
    chk("R10", "last write before abort", last_wr_addr, 16'h0A01);
    rd(4'd2, v); chk("R10", "count kept", v, 16'd3);
    rd(4'd0, v); chk("R10", "source kept", v, 16'h0902);
    rd(4'd8, v); chk("R11", "nmi flag latched", v, 16'h0003);
    wr(4'd8, 16'h0001);
    wait_cycles(15);
    rd(4'd2, v); chk("R6", "resumed to zero", v, 16'h0000);
    rd(4'd0, v); chk("R5", "source after resume", v, 16'h0905);

    summary();
    $finish;
  end
endmodule